// File: doc/BRIEF.md
# Folded Multi-Cycle Unsigned Multiplier

This block multiplies two unsigned W-bit operands and returns the full 2W-bit product. It avoids a full-width combinational array: each operand is cut into a high half and a low half, and the partial products are formed on a small set of half-width multipliers over N_CYC clock cycles. The partial products are summed into an accumulator that is cleared when each new operation starts. The block can take a new operand pair once every N_CYC cycles, with N_CYC at least 2. This lets a design that needs a fractional number of multiplications per cycle pair full-rate multipliers with a cheaper folded one.

Parameter ARCH selects one of two ways to split the operands. The four-product split forms low×low, low×high, high×low and high×high, then shifts each product into place. The three-product split forms low×low, high×high and (high+low)×(high+low), and recovers the middle term by subtraction. That split needs multipliers one bit wider than a half operand. For odd W the high half takes ceil(W/2) bits and the low half takes floor(W/2) bits, and every shift is a multiple of the low-half width. The number of shared multipliers is ceil(terms / N_CYC).

Operands enter on a valid/ready stream. A transfer happens on a rising edge where in_valid and in_ready are both high. While an operation is in flight, in_ready is low and the block applies back-pressure: in_valid and the operand pins are ignored. The result side has no back-pressure. out_valid pulses for one cycle, and out_product keeps its value until the next completion, so a consumer may sample the product in the pulse cycle or at any point afterwards.

Top module: `fold_mult`

## Requirements
- R1: With the four-product split, out_product equals the unsigned product in_a × in_b of the accepted operands, zero-extended to 2W bits. This holds for every operand value, including 0, 1 and all-ones.
- R2: With the three-product split, out_product equals the same unsigned product. This includes odd W, where the high half is ceil(W/2) bits wide.
- R3: When idle, and after reset, in_ready is high. Operands are taken on a rising edge where in_valid and in_ready are both high.
- R4: After an operand pair is accepted, in_ready is low for the next N_CYC-1 cycles. out_valid is high in the cycle that starts N_CYC rising edges after the accepting edge, and in_ready is high again in that same cycle.
- R5: out_valid is high for exactly one cycle per accepted operand pair.
- R6: out_product keeps its value from one completion until the next completion.
- R7: A new pair may be accepted in the cycle where out_valid is high, which gives one product every N_CYC cycles. The new result does not depend on the previous operation, because the accumulator starts from zero.
- R8: While in_ready is low, in_valid, in_a and in_b have no effect. The pending result and the next accepted operation are unchanged.
- R9: A synchronous active-high reset cancels any operation in flight. After reset, out_valid is 0, in_ready is 1 and out_product is 0, and the cancelled operation never produces an out_valid pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operand pair offered |
| in_ready | output | 1 | Block can accept an operand pair this cycle |
| in_a | input | W | Multiplicand, unsigned |
| in_b | input | W | Multiplier, unsigned |
| out_valid | output | 1 | One-cycle pulse: out_product holds a new result |
| out_product | output | 2*W | Full unsigned product, held until the next completion |

## Verification
The assertions assume that reset is held high through the first clock edge and that N_CYC is at least 2. Under that assumption, an acceptance is never also the final step, and the latency counter starts from a known value. They do not assume that in_valid stays low while the block is busy. The stimulus deliberately drives in_valid high with unrelated operands during busy cycles, and offers a new pair in the very cycle a result appears, so the back-pressure rules are exercised at their edges. Two instances run from the same stimulus: an even-width four-product build and an odd-width three-product build with N_CYC of 3. Operands come from a fixed vector table, from random draws and from the values 0, 1 and all-ones.

// File: rtl/fm_pkg.sv
package fm_pkg;

  // Selects how the operands are split into half-width partial products.
  typedef enum logic {
    FM_SCHOOL = 1'b0,  // four products, shifted and summed
    FM_KARA   = 1'b1   // three products, middle term by subtraction
  } fm_arch_e;

  // Number of partial products one multiplication needs.
  function automatic int fm_terms(fm_arch_e arch);
    return (arch == FM_KARA) ? 3 : 4;
  endfunction

  // Number of shared multipliers so that all terms fit in n cycles.
  function automatic int fm_lanes(fm_arch_e arch, int n);
    return (fm_terms(arch) + n - 1) / n;
  endfunction

  // Width of the step counter for an n-cycle schedule.
  function automatic int fm_stepw(int n);
    return (n > 2) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/fm_pp_mul.sv
// Shared narrow multiplier: the only array in the block.
module fm_pp_mul #(
  parameter int MW = 8
) (
  input  logic [MW-1:0]   x,
  input  logic [MW-1:0]   y,
  output logic [2*MW-1:0] p
);
  assign p = (2*MW)'(x) * (2*MW)'(y);
endmodule

// File: rtl/fm_ctrl.sv
// Sequencer: accepts a pair, walks N_CYC steps, pulses completion.
module fm_ctrl #(
  parameter int N_CYC = 2,
  parameter int SW    = fm_pkg::fm_stepw(N_CYC)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  output logic          in_ready,
  output logic          accept,
  output logic          active,
  output logic          first,
  output logic          last,
  output logic [SW-1:0] step,
  output logic          out_valid
);
  localparam logic [SW-1:0] STEP_LAST = SW'(N_CYC - 1);
  localparam int            CW        = $clog2(N_CYC + 1);

  logic          busy_q;
  logic [SW-1:0] step_q;
  logic          done_q;

  assign in_ready  = !busy_q;
  assign accept    = in_valid && !busy_q;
  assign active    = accept || busy_q;
  assign step      = busy_q ? step_q : '0;
  assign first     = accept;
  assign last      = active && (step == STEP_LAST);
  assign out_valid = done_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      step_q <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= last;
      if (accept) begin
        busy_q <= 1'b1;
        step_q <= SW'(1);
      end else if (busy_q) begin
        if (step_q == STEP_LAST) begin
          busy_q <= 1'b0;
          step_q <= '0;
        end else begin
          step_q <= step_q + SW'(1);
        end
      end
    end
  end

  // Independent latency counter for the checks below.
  logic [CW-1:0] lat_q;
  always_ff @(posedge clk) begin
    if (rst)          lat_q <= '0;
    else if (accept)  lat_q <= CW'(1);
    else if (busy_q)  lat_q <= lat_q + CW'(1);
  end

  assert_latency_R4: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (lat_q == CW'(N_CYC)));

  assert_ready_back_R4: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> in_ready);

  assert_busy_after_accept_R4: assert property (@(posedge clk) disable iff (rst)
    accept |=> !in_ready);

  assert_single_pulse_R5: assert property (@(posedge clk) disable iff (rst)
    out_valid |=> !out_valid);

endmodule

// File: rtl/fm_lane.sv
// One shared multiplier lane: picks the term scheduled for this step,
// multiplies the half operands, and shapes the product into its weight.
module fm_lane #(
  parameter int               W     = 16,
  parameter fm_pkg::fm_arch_e ARCH  = fm_pkg::FM_SCHOOL,
  parameter int               LANE  = 0,
  parameter int               LANES = 2,
  parameter int               SW    = 1
) (
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b,
  input  logic [SW-1:0]  step,
  output logic [2*W-1:0] contrib
);
  localparam int WL = W / 2;
  localparam int WH = W - WL;
  localparam int MW = (ARCH == fm_pkg::FM_KARA) ? WH + 1 : WH;
  localparam int PW = 2 * W;

  logic [WH-1:0]   a_hi, b_hi;
  logic [WL-1:0]   a_lo, b_lo;
  logic [MW-1:0]   x, y;
  logic [2*MW-1:0] p;
  logic [PW-1:0]   pe;
  int              k;

  assign a_hi = a[W-1:WL];
  assign b_hi = b[W-1:WL];
  assign a_lo = a[WL-1:0];
  assign b_lo = b[WL-1:0];

  always_comb k = int'(step) * LANES + LANE;

  fm_pp_mul #(.MW(MW)) u_mul (.x(x), .y(y), .p(p));

  assign pe = PW'(p);

  if (ARCH == fm_pkg::FM_KARA) begin : g_kara
    always_comb begin
      x = '0;
      y = '0;
      case (k)
        0: begin x = MW'(a_lo); y = MW'(b_lo); end
        1: begin x = MW'(a_hi); y = MW'(b_hi); end
        2: begin x = MW'(a_hi) + MW'(a_lo); y = MW'(b_hi) + MW'(b_lo); end
        default: ;
      endcase
    end
    // Arithmetic wraps modulo 2^(2W); the total is exact as it fits.
    always_comb begin
      case (k)
        0:       contrib = pe - (pe << WL);
        1:       contrib = (pe << (2 * WL)) - (pe << WL);
        2:       contrib = pe << WL;
        default: contrib = '0;
      endcase
    end
  end else begin : g_school
    always_comb begin
      x = '0;
      y = '0;
      case (k)
        0: begin x = MW'(a_lo); y = MW'(b_lo); end
        1: begin x = MW'(a_lo); y = MW'(b_hi); end
        2: begin x = MW'(a_hi); y = MW'(b_lo); end
        3: begin x = MW'(a_hi); y = MW'(b_hi); end
        default: ;
      endcase
    end
    always_comb begin
      case (k)
        0:       contrib = pe;
        1, 2:    contrib = pe << WL;
        3:       contrib = pe << (2 * WL);
        default: contrib = '0;
      endcase
    end
  end

endmodule

// File: rtl/fold_mult.sv
// Folded unsigned multiplier: one product every N_CYC cycles.
module fold_mult #(
  parameter int               W     = 16,
  parameter int               N_CYC = 2,
  parameter fm_pkg::fm_arch_e ARCH  = fm_pkg::FM_SCHOOL
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           in_valid,
  output logic           in_ready,
  input  logic [W-1:0]   in_a,
  input  logic [W-1:0]   in_b,
  output logic           out_valid,
  output logic [2*W-1:0] out_product
);
  localparam int PW = 2 * W;
  localparam int M  = fm_pkg::fm_lanes(ARCH, N_CYC);
  localparam int SW = fm_pkg::fm_stepw(N_CYC);

  if (N_CYC < 2) begin : g_bad_ncyc
    $error("fold_mult: N_CYC must be at least 2");
  end

  logic          accept, active, first, last;
  logic [SW-1:0] step;
  logic [W-1:0]  a_q, b_q, a_cur, b_cur;
  logic [PW-1:0] acc_q, prod_q, lane_sum, acc_next;
  logic [PW-1:0] lane_c [M];

  fm_ctrl #(.N_CYC(N_CYC), .SW(SW)) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .accept   (accept),
    .active   (active),
    .first    (first),
    .last     (last),
    .step     (step),
    .out_valid(out_valid)
  );

  // Step 0 runs in the accepting cycle straight from the input pins.
  assign a_cur = accept ? in_a : a_q;
  assign b_cur = accept ? in_b : b_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      a_q <= '0;
      b_q <= '0;
    end else if (accept) begin
      a_q <= in_a;
      b_q <= in_b;
    end
  end

  for (genvar g = 0; g < M; g++) begin : g_lane
    fm_lane #(
      .W(W), .ARCH(ARCH), .LANE(g), .LANES(M), .SW(SW)
    ) u_lane (
      .a      (a_cur),
      .b      (b_cur),
      .step   (step),
      .contrib(lane_c[g])
    );
  end

  always_comb begin
    lane_sum = '0;
    for (int i = 0; i < M; i++) lane_sum = lane_sum + lane_c[i];
  end

  assign acc_next = (first ? '0 : acc_q) + lane_sum;

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q  <= '0;
      prod_q <= '0;
    end else begin
      if (active) acc_q  <= acc_next;
      if (last)   prod_q <= acc_next;
    end
  end

  assign out_product = prod_q;

  assert_hold_product_R6: assert property (@(posedge clk) disable iff (rst)
    !last |=> $stable(out_product));

  assert_ops_frozen_R8: assert property (@(posedge clk) disable iff (rst)
    !in_ready |=> ($stable(a_q) && $stable(b_q)));

endmodule

// File: tb/fold_mult_tb.sv
`timescale 1ns/1ps
module fold_mult_tb;
  localparam int WS = 16;
  localparam int WK = 13;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic [WS-1:0] in_a = '0, in_b = '0;
  logic rdy_s, ov_s, rdy_k, ov_k;
  logic [2*WS-1:0] prod_s;
  logic [2*WK-1:0] prod_k;
  int checks = 0;
  int fails = 0;

  always #4 clk = ~clk;

  fold_mult #(.W(WS), .N_CYC(2), .ARCH(fm_pkg::FM_SCHOOL)) u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(rdy_s),
    .in_a(in_a), .in_b(in_b), .out_valid(ov_s), .out_product(prod_s));

  fold_mult #(.W(WK), .N_CYC(3), .ARCH(fm_pkg::FM_KARA)) u_dut_k (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(rdy_k),
    .in_a(in_a[WK-1:0]), .in_b(in_b[WK-1:0]), .out_valid(ov_k),
    .out_product(prod_k));

  localparam logic [31:0] VEC [12] = '{
    32'h0000_0000, 32'h0001_0001, 32'hFFFF_FFFF, 32'hFFFF_0001,
    32'h0000_FFFF, 32'h8000_8000, 32'h00FF_FF00, 32'h1234_5678,
    32'hAAAA_5555, 32'h1FFF_1FFF, 32'h0001_FFFF, 32'hF0F0_0F0F};

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] ps(input logic [WS-1:0] a, input logic [WS-1:0] b);
    return 64'(a) * 64'(b);
  endfunction

  function automatic logic [63:0] pk(input logic [WS-1:0] a, input logic [WS-1:0] b);
    return 64'(a[WK-1:0]) * 64'(b[WK-1:0]);
  endfunction

  // One operation on both instances; optional junk offered while busy (R8).
  task automatic run_op(input logic [WS-1:0] a, input logic [WS-1:0] b, input bit junk);
    @(negedge clk);
    chk("R3 ready idle four-product", 64'(rdy_s), 64'd1);
    chk("R3 ready idle three-product", 64'(rdy_k), 64'd1);
    in_valid = 1'b1; in_a = a; in_b = b;
    @(negedge clk);
    if (junk) begin
      in_valid = 1'b1; in_a = ~a; in_b = b ^ 16'h5A5A;
    end else begin
      in_valid = 1'b0;
    end
    chk("R4 ready low while busy (a)", 64'(rdy_s), 64'd0);
    chk("R4 ready low while busy (k)", 64'(rdy_k), 64'd0);
    @(negedge clk);
    in_valid = 1'b0;
    chk("R4 out_valid after N_CYC=2", 64'(ov_s), 64'd1);
    chk("R4 ready back with result", 64'(rdy_s), 64'd1);
    chk(junk ? "R8 busy input ignored" : "R1 four-product result", 64'(prod_s), ps(a, b));
    chk("R4 three-product not yet done", 64'(ov_k), 64'd0);
    @(negedge clk);
    chk("R5 single pulse", 64'(ov_s), 64'd0);
    chk("R6 product held", 64'(prod_s), ps(a, b));
    chk("R4 out_valid after N_CYC=3", 64'(ov_k), 64'd1);
    chk(junk ? "R8 busy input ignored (k)" : "R2 three-product result", 64'(prod_k), pk(a, b));
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL R4 watchdog: actual hang expected completion");
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin : main
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    chk("R9 reset out_valid", 64'(ov_s), 64'd0);
    chk("R9 reset ready", 64'(rdy_s), 64'd1);
    chk("R9 reset product", 64'(prod_s), 64'd0);
    chk("R9 reset out_valid (k)", 64'(ov_k), 64'd0);

    for (int i = 0; i < 12; i++) run_op(VEC[i][31:16], VEC[i][15:0], 1'b0);
    for (int i = 0; i < 40; i++) run_op(WS'($urandom), WS'($urandom), i[0]);

    // R7: back-to-back on the two-cycle instance while the other is busy.
    @(negedge clk);
    in_valid = 1'b1; in_a = 16'hBEEF; in_b = 16'h1357;
    @(negedge clk);
    in_valid = 1'b0;
    @(negedge clk);
    chk("R7 first result", 64'(prod_s), ps(16'hBEEF, 16'h1357));
    chk("R7 ready in result cycle", 64'(rdy_s), 64'd1);
    in_valid = 1'b1; in_a = 16'hFFFF; in_b = 16'h0003;
    @(negedge clk);
    in_valid = 1'b0;
    chk("R7 second pair taken", 64'(rdy_s), 64'd0);
    chk("R6 held across new op", 64'(prod_s), ps(16'hBEEF, 16'h1357));
    chk("R8 busy instance ignored offer", 64'(prod_k), pk(16'hBEEF, 16'h1357));
    chk("R8 busy instance completes", 64'(ov_k), 64'd1);
    @(negedge clk);
    chk("R7 back-to-back valid", 64'(ov_s), 64'd1);
    chk("R7 accumulator cleared", 64'(prod_s), ps(16'hFFFF, 16'h0003));
    chk("R8 no extra op (k)", 64'(ov_k), 64'd0);

    // R9: reset in the middle of an operation.
    @(negedge clk);
    in_valid = 1'b1; in_a = 16'h4321; in_b = 16'h8765;
    @(negedge clk);
    in_valid = 1'b0; rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk("R9 aborted out_valid", 64'(ov_s), 64'd0);
    chk("R9 ready after abort", 64'(rdy_s), 64'd1);
    chk("R9 product cleared", 64'(prod_s), 64'd0);
    @(negedge clk);
    chk("R9 no late pulse", 64'(ov_s), 64'd0);
    chk("R9 no late pulse (k)", 64'(ov_k), 64'd0);

    run_op(16'hFFFF, 16'hFFFF, 1'b0);
    run_op(16'h0001, 16'h0000, 1'b1);

    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule